// File: doc/BRIEF.md
# External Bus Address Hold Controller

This block turns internal bus requests into cycles on an external address and data bus. Each request names an address, a direction, a byte or word size, whether it targets internal or external space, and whether the addressed external area is 8 or 16 bits wide. External cycles drive the address pins, pulse an active-low read or write strobe, and answer the core with a one-clock ready. Internal-space cycles take one clock and never strobe the pins. A word access to an 8-bit area is split into two byte cycles, even address first.

A mode bit, written through a one-bit configuration port, picks how the address pins behave. In the normal mode the pins follow every bus cycle, including internal ones and refresh cycles, which show a fixed refresh start address. In the hold mode the pins keep the last external address until the next external cycle begins. This keeps the address steady for slow external devices that sample it after the strobe rises. A level refresh request wins over a waiting access at a cycle boundary and produces a one-clock refresh cycle.

Top module: `ext_addr_hold_ctrl`

## Requirements
- R1: After reset the address pins are zero, both strobes are high (inactive), ready and refresh_cyc are low, and the block is in normal mode.
- R2: When mode_we is high at a clock edge, mode_in is stored; 1 selects the hold mode and 0 the normal mode.
- R3: An external cycle takes two clocks. The address is loaded at the edge that starts it, and the strobe is low only in the second clock: ext_rd_n for reads and ext_wr_n for writes. The address is stable while a strobe is low, and req_ready is high during the final strobe clock.
- R4: In normal mode, an internal-space cycle (req_ext=0) loads its address onto the pins and gives one clock of req_ready without any strobe.
- R5: In hold mode, internal-space cycles leave the address pins unchanged. The pins change only at the start of an external cycle.
- R6: A refresh cycle lasts one clock with refresh_cyc high. In normal mode the pins show REF_ADDR; in hold mode they keep their previous value.
- R7: A word access (req_word=1) to an 8-bit area (req_bus8=1) runs two external cycles, at the even and then the odd address. A write drives the high byte and then the low byte on ext_dout[7:0]. A read returns {even byte, odd byte}, each taken from ext_din[7:0], with a single req_ready pulse.
- R8: When refresh_req and a request are both pending in idle, the refresh runs first. A refresh never starts between the two halves of a split word.
- R9: Byte accesses use data lane [7:0], with req_rdata[15:8] zero. Word accesses to a 16-bit area use all 16 lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_we | input | 1 | Write strobe for the address mode bit |
| mode_in | input | 1 | Mode value: 1 hold, 0 normal |
| req_valid | input | 1 | Request pending, held until req_ready |
| req_ext | input | 1 | 1 external space, 0 internal space |
| req_write | input | 1 | 1 write, 0 read |
| req_word | input | 1 | 1 word, 0 byte |
| req_bus8 | input | 1 | Addressed external area is 8 bits wide |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Write data |
| req_ready | output | 1 | Request completed this clock |
| req_rdata | output | DW | Read data, valid with req_ready on external reads |
| refresh_req | input | 1 | Refresh wanted (level) |
| refresh_cyc | output | 1 | Refresh cycle in progress |
| ext_addr | output | AW | External address pins |
| ext_rd_n | output | 1 | Active-low read strobe |
| ext_wr_n | output | 1 | Active-low write strobe |
| ext_dout | output | DW | External write data |
| ext_din | input | DW | External read data |

## Verification
Internal, external and refresh cycles are interleaved in both modes. This separates pins that follow every cycle from pins that move only on external cycles. Byte, 16-bit word and split word accesses are run in both directions and tell apart the lane placement, the even-then-odd address order and the byte assembly order. Refresh is raised together with a fresh request and again in the middle of a split word, which shows whether the refresh is granted first at a boundary and is kept out from between the halves.

// File: rtl/ext_addr_hold_ctrl.sv
module ext_addr_hold_ctrl #(
  parameter int AW = 24,
  parameter int DW = 16,
  parameter logic [AW-1:0] REF_ADDR = 24'h000400
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_we,
  input  logic          mode_in,
  input  logic          req_valid,
  input  logic          req_ext,
  input  logic          req_write,
  input  logic          req_word,
  input  logic          req_bus8,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic [DW-1:0] req_rdata,
  input  logic          refresh_req,
  output logic          refresh_cyc,
  output logic [AW-1:0] ext_addr,
  output logic          ext_rd_n,
  output logic          ext_wr_n,
  output logic [DW-1:0] ext_dout,
  input  logic [DW-1:0] ext_din
);
  localparam int BW = DW / 2;

  typedef enum logic [2:0] {S_IDLE, S_INT, S_ADR, S_STB, S_REF} st_t;

  st_t           st;
  logic          hold_q;
  logic [AW-1:0] lat_addr;
  logic [DW-1:0] lat_wdata;
  logic          lat_wr, lat_word, lat_split, half2;
  logic [BW-1:0] hi_byte;
  logic          strobe, last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      hold_q    <= 1'b0;
      lat_addr  <= '0;
      lat_wdata <= '0;
      lat_wr    <= 1'b0;
      lat_word  <= 1'b0;
      lat_split <= 1'b0;
      half2     <= 1'b0;
      hi_byte   <= '0;
      ext_addr  <= '0;
    end else begin
      if (mode_we) hold_q <= mode_in;
      case (st)
        S_IDLE: begin
          if (refresh_req) begin
            st <= S_REF;
            if (!hold_q) ext_addr <= REF_ADDR;
          end else if (req_valid) begin
            lat_addr  <= req_addr;
            lat_wdata <= req_wdata;
            lat_wr    <= req_write;
            lat_word  <= req_word;
            lat_split <= req_word && req_bus8;
            half2     <= 1'b0;
            if (req_ext) begin
              st <= S_ADR;
              ext_addr <= (req_word && req_bus8) ? {req_addr[AW-1:1], 1'b0} : req_addr;
            end else begin
              st <= S_INT;
              if (!hold_q) ext_addr <= req_addr;
            end
          end
        end
        S_ADR: st <= S_STB;
        S_STB: begin
          if (lat_split && !half2) begin
            half2    <= 1'b1;
            hi_byte  <= ext_din[BW-1:0];
            ext_addr <= {lat_addr[AW-1:1], 1'b1};
            st       <= S_ADR;
          end else begin
            st <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign strobe      = (st == S_STB);
  assign last        = strobe && !(lat_split && !half2);
  assign ext_rd_n    = !(strobe && !lat_wr);
  assign ext_wr_n    = !(strobe && lat_wr);
  assign req_ready   = (st == S_INT) || last;
  assign refresh_cyc = (st == S_REF);

  assign ext_dout = lat_split ? {{BW{1'b0}}, (half2 ? lat_wdata[BW-1:0] : lat_wdata[DW-1:BW])}
                  : lat_word  ? lat_wdata
                  :             {{BW{1'b0}}, lat_wdata[BW-1:0]};

  assign req_rdata = (st != S_STB) ? '0
                   : lat_split ? {hi_byte, ext_din[BW-1:0]}
                   : lat_word  ? ext_din
                   :             {{BW{1'b0}}, ext_din[BW-1:0]};

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (ext_addr == '0 && !hold_q && ext_rd_n && ext_wr_n && !req_ready));

  assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ext_rd_n && !ext_wr_n));

  assert_addr_steady_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_rd_n || !ext_wr_n) |-> $stable(ext_addr));

  assert_hold_internal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && $past(hold_q) && (st == S_INT || st == S_REF)) |-> $stable(ext_addr));

  assert_hold_moves_on_ext_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && $past(hold_q) && !$stable(ext_addr)) |-> (st == S_ADR));

  assert_single_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready);

  assert_refresh_boundary_R8: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_cyc |-> $past(st == S_IDLE));
endmodule

// File: tb/ext_addr_hold_ctrl_tb.sv
module ext_addr_hold_ctrl_tb;
  localparam logic [23:0] REF = 24'h000400;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mode_we = 0, mode_in = 0;
  logic req_valid = 0, req_ext = 0, req_write = 0, req_word = 0, req_bus8 = 0;
  logic [23:0] req_addr = '0;
  logic [15:0] req_wdata = '0, ext_din = '0;
  logic refresh_req = 0;
  logic req_ready, refresh_cyc, ext_rd_n, ext_wr_n;
  logic [15:0] req_rdata, ext_dout;
  logic [23:0] ext_addr;

  int nchk = 0, nerr = 0;
  logic [23:0] exp_addr = '0;
  bit m_hold = 0, mon_en = 0, finished = 0, ref_mid = 0;

  always #2 clk = ~clk;

  ext_addr_hold_ctrl #(.AW(24), .DW(16), .REF_ADDR(REF)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_in(mode_in),
    .req_valid(req_valid), .req_ext(req_ext), .req_write(req_write),
    .req_word(req_word), .req_bus8(req_bus8), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(req_ready), .req_rdata(req_rdata),
    .refresh_req(refresh_req), .refresh_cyc(refresh_cyc), .ext_addr(ext_addr),
    .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n), .ext_dout(ext_dout), .ext_din(ext_din));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (mon_en) begin
    #1 chk("R5 address pins vs model", {8'h0, ext_addr}, {8'h0, exp_addr});
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic set_mode(input bit v);
    mode_we = 1; mode_in = v;
    step();
    mode_we = 0; m_hold = v;
  endtask

  task automatic int_acc(input logic [23:0] a);
    req_valid = 1; req_ext = 0; req_write = 0; req_word = 0; req_bus8 = 0; req_addr = a;
    step();
    if (!m_hold) exp_addr = a;
    #1;
    chk("R4 internal ready", {31'h0, req_ready}, 32'h1);
    chk("R4 no strobe on internal", {30'h0, ext_rd_n, ext_wr_n}, 32'h3);
    req_valid = 0;
    step();
  endtask

  task automatic ext_body(input logic [23:0] a, input bit wr, input bit wd, input bit b8,
                          input logic [15:0] wdat, input logic [15:0] din);
    bit sp;
    int nh;
    sp = wd && b8;
    nh = sp ? 2 : 1;
    for (int h = 0; h < nh; h++) begin
      step();
      exp_addr = sp ? {a[23:1], h[0]} : a;
      #1;
      chk("R3 no strobe in address clock", {30'h0, ext_rd_n, ext_wr_n}, 32'h3);
      chk("R3 no ready in address clock", {31'h0, req_ready}, 32'h0);
      chk("R8 no refresh inside access", {31'h0, refresh_cyc}, 32'h0);
      if (ref_mid && h == 0) refresh_req = 1;
      step();
      ext_din = sp ? (h == 0 ? {8'h00, din[15:8]} : {8'h00, din[7:0]}) : din;
      #1;
      chk("R3 strobe levels", {30'h0, ext_rd_n, ext_wr_n}, wr ? 32'h2 : 32'h1);
      chk("R7 single ready at final half", {31'h0, req_ready}, (h == nh - 1) ? 32'h1 : 32'h0);
      chk("R8 no refresh inside access", {31'h0, refresh_cyc}, 32'h0);
      if (wr)
        chk(sp ? "R7 split write lane" : "R9 write lanes", {16'h0, ext_dout},
            sp ? {24'h0, (h == 0 ? wdat[15:8] : wdat[7:0])} : (wd ? {16'h0, wdat} : {24'h0, wdat[7:0]}));
      else if (h == nh - 1)
        chk(sp ? "R7 split read assembly" : "R9 read lanes", {16'h0, req_rdata},
            (sp || wd) ? {16'h0, din} : {24'h0, din[7:0]});
    end
    req_valid = 0;
    step();
  endtask

  task automatic ext_acc(input logic [23:0] a, input bit wr, input bit wd, input bit b8,
                         input logic [15:0] wdat, input logic [15:0] din);
    req_valid = 1; req_ext = 1; req_write = wr; req_word = wd; req_bus8 = b8;
    req_addr = a; req_wdata = wdat;
    ext_body(a, wr, wd, b8, wdat, din);
  endtask

  task automatic refresh();
    refresh_req = 1;
    step();
    if (!m_hold) exp_addr = REF;
    #1 chk("R6 refresh cycle", {31'h0, refresh_cyc}, 32'h1);
    refresh_req = 0;
    step();
    #1 chk("R6 refresh lasts one clock", {31'h0, refresh_cyc}, 32'h0);
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1;
    #1;
    chk("R1 reset address", {8'h0, ext_addr}, 32'h0);
    chk("R1 reset strobes", {30'h0, ext_rd_n, ext_wr_n}, 32'h3);
    chk("R1 reset ready/refresh", {30'h0, req_ready, refresh_cyc}, 32'h0);
    mon_en = 1;
    step();

    int_acc(24'h001234);
    ext_acc(24'h200010, 0, 0, 0, 16'h0000, 16'hABCD);
    ext_acc(24'h200020, 1, 1, 0, 16'h1357, 16'h0000);
    ext_acc(24'h200031, 1, 0, 0, 16'h77E4, 16'h0000);
    refresh();
    ext_acc(24'h300021, 0, 1, 1, 16'h0000, 16'h5AC3);
    ext_acc(24'h300040, 1, 1, 1, 16'hBEEF, 16'h0000);
    int_acc(24'h00ABCD);

    set_mode(1);
    ext_acc(24'h400100, 0, 1, 0, 16'h0000, 16'h9182);
    int_acc(24'h002222);
    #1 chk("R2 hold mode keeps pins", {8'h0, ext_addr}, 32'h400100);
    refresh();
    int_acc(24'h003333);
    ext_acc(24'h400200, 1, 0, 0, 16'h0042, 16'h0000);

    req_valid = 1; req_ext = 1; req_write = 0; req_word = 1; req_bus8 = 0;
    req_addr = 24'h500000; req_wdata = '0; refresh_req = 1;
    step();
    #1;
    chk("R8 refresh granted first", {31'h0, refresh_cyc}, 32'h1);
    chk("R8 no strobe during refresh", {30'h0, ext_rd_n, ext_wr_n}, 32'h3);
    refresh_req = 0;
    step();
    ext_body(24'h500000, 0, 1, 0, 16'h0000, 16'h2468);

    ref_mid = 1;
    ext_acc(24'h600011, 0, 1, 1, 16'h0000, 16'hC001);
    ref_mid = 0;
    #1 chk("R8 refresh waits for boundary", {31'h0, refresh_cyc}, 32'h0);
    step();
    #1 chk("R8 refresh after split", {31'h0, refresh_cyc}, 32'h1);
    refresh_req = 0;
    step();

    set_mode(0);
    int_acc(24'h004444);
    #1 chk("R2 normal mode follows internal", {8'h0, ext_addr}, 32'h004444);
    refresh();
    step();

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nchk++; nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule